// File: doc/BRIEF.md
# Programmable Mixed-Radix Frequency Divider

The block divides its clock by a programmed ratio N and marks the end of every division cycle with a one-clock HIGH pulse. It counts down through a chain of stages. The lowest stage has a selectable modulus m of 2, 4, 5, 8 or 10. Above it sit three decade stages and a small top stage. Every stage is preset from its own parallel input. The ratio is N = m·(1000·T + 100·C + 10·B + A) + F, where F is the lowest-stage preset, A, B and C are the decade presets from low to high, and T is the top-stage preset. A decade preset may go up to 15. Such a digit stretches only the first pass of that decade; every later pass of that decade counts ten.

A typical use is the feedback divider of a frequency synthesizer loop, or a fixed or timeout divider. A hold code freezes the chain on the presets. When the hold is left, the first edge only arms the chain, which adds one count before the first pulse. One decimal code can run either with a fixed ratio of 10000 or with the programmed ratio. The output is either decoded directly from the count or taken through a register.

Top module: `pdiv_counter`

## Requirements
- R1: mode_sel picks the lowest-stage modulus m: 111 gives 2, 011 gives 4, 101 gives 5, 001 gives 8, 110 and 010 give 10, and 000 gives 10 (decimal). In steady counting, div_out pulses once every N clocks, with N = m·(1000·T + 100·C + 10·B + A) + F. pre_dec holds A in bits [3:0], B in bits [7:4] and C in bits [11:8].
- R2: A decade preset from 10 to 15 counts in full on the first pass. Each later pass of that decade counts 10. For example, m=4, A=15, F=3 gives N=63, and m=8, A=B=C=15, T=1, F=7 gives N=21327.
- R3: Presets above the range of the selected mode are saturated. F is limited to m−1. T is limited to 7 for m=2, 3 for m=4, 1 for m=5, 1 for m=8 and 0 for m=10 or decimal.
- R4: mode_sel=100 is the hold mode. While it lasts, every stage loads its preset on each edge and div_out stays LOW. The mode must be held for at least 2 clocks.
- R5: After the hold mode or reset, the first edge in a counting mode only loads the presets and arms the chain. The first pulse of the direct output appears after the N-th edge, counting that arming edge as the first.
- R6: At the terminal count in a counting mode, all stages reload from their presets, so every following cycle is N clocks long.
- R7: If the hold mode begins when two or fewer clocks remain before a pulse, that pulse still appears at its normal time. The chain then holds.
- R8: With mode_sel=000 and out_direct=0, the block divides by a fixed 10000 and ignores the presets. The only exception is the first cycle after the hold mode or reset, whose length is set by the presets.
- R9: With out_direct=1, div_out is decoded directly from the count. The pulse is one clock wide and appears during the cycle after the N-th edge. With out_direct=0, div_out is the same pulse delayed by one register, which adds one clock to the first pulse and leaves the period unchanged.
- R10: rst is asynchronous and active high. It forces div_out LOW at once and clears the arming flag, so the next edge after release acts as an arming edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| mode_sel | input | 3 | Mode code selecting modulus, decimal or hold |
| out_direct | input | 1 | 1: direct decoded output; 0: registered output (fixed 10000 in decimal code) |
| pre_first | input | DIGIT_W | Lowest-stage preset F |
| pre_dec | input | NUM_DEC·DIGIT_W | Decade presets A, B, C from low to high nibble |
| pre_last | input | LAST_W | Top-stage preset T |
| div_out | output | 1 | Division pulse |

## Verification
The ratio formula is tried in every modulus code with presets that set different stages. Small ratios expose an off-by-one in the lowest stage. Decade digits above 9 separate a chain that re-wraps to 9 from one that keeps the large digit on every pass. The largest divide-by-8 setting and an out-of-range top and lowest preset show whether saturation is applied per mode. The fixed decimal run changes the presets in mid-cycle to show they are ignored. A hold request two clocks before a pulse tells an immediate hold from one that lets the pulse out first. A reset in mid-pulse checks that the output drops at once and that counting restarts with an arming edge.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

  // Decoded view of the mode code
  typedef struct packed {
    logic [3:0] modulus;   // lowest-stage modulus m
    logic [2:0] last_max;  // largest allowed top-stage preset
    logic       hold;      // continuous preset load
    logic       decimal;   // decimal code (fixed ratio when registered)
  } pdiv_cfg_t;

  function automatic pdiv_cfg_t pdiv_decode(input logic [2:0] code);
    pdiv_cfg_t c;
    c = '{modulus: 4'd10, last_max: 3'd0, hold: 1'b0, decimal: 1'b0};
    case (code)
      3'b111: begin c.modulus = 4'd2; c.last_max = 3'd7; end
      3'b011: begin c.modulus = 4'd4; c.last_max = 3'd3; end
      3'b101: begin c.modulus = 4'd5; c.last_max = 3'd1; end
      3'b001: begin c.modulus = 4'd8; c.last_max = 3'd1; end
      3'b100: c.hold    = 1'b1;
      3'b000: c.decimal = 1'b1;
      default: ;
    endcase
    return c;
  endfunction

  // Saturate a preset to an upper bound
  function automatic int unsigned pdiv_clamp(input int unsigned v, input int unsigned lim);
    return (v > lim) ? lim : v;
  endfunction

endpackage

// File: rtl/pdiv_mode_dec.sv
module pdiv_mode_dec
  import pdiv_pkg::*;
(
  input  logic [2:0] code,
  output pdiv_cfg_t  cfg
);
  always_comb cfg = pdiv_decode(code);
endmodule

// File: rtl/pdiv_stage.sv
// One down-counting digit of the chain: loads, decrements, wraps on borrow.
module pdiv_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         cnt_en,
  input  logic [W-1:0] wrap_val,
  output logic [W-1:0] val,
  output logic         zero,
  output logic         borrow
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)         val <= '0;
    else if (load)   val <= load_val;
    else if (cnt_en) val <= zero ? wrap_val : val - W'(1);
  end

  assign zero   = (val == '0);
  assign borrow = cnt_en & zero;

  // A digit that underflows restarts at its wrap value (10-count passes after a large preset)
  AST_STAGE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !load && zero) |=> (val == $past(wrap_val)));  // R2
endmodule

// File: rtl/pdiv_out.sv
// Output select: direct decode or one register stage.
module pdiv_out (
  input  logic clk,
  input  logic rst,
  input  logic pulse_in,
  input  logic direct,
  output logic div_out
);
  logic pulse_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= pulse_in;
  end

  assign div_out = direct ? pulse_in : pulse_q;

  AST_REG_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_q) |-> $past(pulse_in));  // R9
endmodule

// File: rtl/pdiv_counter.sv
module pdiv_counter
  import pdiv_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter int NUM_DEC = 3,
  parameter int LAST_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [2:0]                 mode_sel,
  input  logic                       out_direct,
  input  logic [DIGIT_W-1:0]         pre_first,
  input  logic [NUM_DEC*DIGIT_W-1:0] pre_dec,
  input  logic [LAST_W-1:0]          pre_last,
  output logic                       div_out
);
  localparam logic [DIGIT_W-1:0] DEC_WRAP = DIGIT_W'(9);
  localparam logic [LAST_W-1:0]  FIX_LAST = LAST_W'(1);

  pdiv_cfg_t cfg;
  pdiv_mode_dec u_dec (.code(mode_sel), .cfg(cfg));

  // Named control events
  logic hold_req, inhibit, run_q, run_d;
  logic load, cnt, use_fixed;
  logic upper_zero, term, near, pulse_comb;

  assign hold_req = cfg.hold;
  assign inhibit  = cfg.decimal & ~out_direct;

  // Lowest stage
  logic [DIGIT_W-1:0] first_val, first_ld, first_wrap;
  logic               first_zero, first_borrow;

  assign first_wrap = DIGIT_W'(cfg.modulus - 4'd1);
  assign first_ld   = use_fixed ? '0
                    : DIGIT_W'(pdiv_clamp(32'(pre_first), 32'(cfg.modulus) - 32'd1));

  pdiv_stage #(.W(DIGIT_W)) u_first (
    .clk(clk), .rst(rst), .load(load), .load_val(first_ld),
    .cnt_en(cnt), .wrap_val(first_wrap),
    .val(first_val), .zero(first_zero), .borrow(first_borrow)
  );

  // Decade stages
  logic [NUM_DEC:0]   chain;
  logic [NUM_DEC-1:0] dec_zero;
  assign chain[0] = first_borrow;

  for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
    logic [DIGIT_W-1:0] ld, v;
    assign ld = use_fixed ? '0 : pre_dec[i*DIGIT_W +: DIGIT_W];
    pdiv_stage #(.W(DIGIT_W)) u_d (
      .clk(clk), .rst(rst), .load(load), .load_val(ld),
      .cnt_en(chain[i]), .wrap_val(DEC_WRAP),
      .val(v), .zero(dec_zero[i]), .borrow(chain[i+1])
    );
  end

  // Top stage
  logic [LAST_W-1:0] last_val, last_ld;
  logic              last_zero, last_borrow;

  assign last_ld = use_fixed ? FIX_LAST
                 : LAST_W'(pdiv_clamp(32'(pre_last), 32'(cfg.last_max)));

  pdiv_stage #(.W(LAST_W)) u_last (
    .clk(clk), .rst(rst), .load(load), .load_val(last_ld),
    .cnt_en(chain[NUM_DEC]), .wrap_val('0),
    .val(last_val), .zero(last_zero), .borrow(last_borrow)
  );

  // Terminal and near-terminal decode
  assign upper_zero = (&dec_zero) & last_zero;
  assign term       = upper_zero & (first_val <= DIGIT_W'(1));
  assign near       = upper_zero & (first_val <= DIGIT_W'(2));
  assign pulse_comb = run_q & term;

  // Sequencing: arm, hold, reload, count
  always_comb begin
    load      = 1'b0;
    cnt       = 1'b0;
    use_fixed = 1'b0;
    run_d     = run_q;
    if (!run_q) begin
      load  = 1'b1;
      run_d = ~hold_req;
    end else if (hold_req) begin
      if (near && !term) cnt = 1'b1;
      else begin
        load  = 1'b1;
        run_d = 1'b0;
      end
    end else if (term) begin
      load      = 1'b1;
      use_fixed = inhibit;
    end else begin
      cnt = 1'b1;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= run_d;
  end

  pdiv_out u_out (
    .clk(clk), .rst(rst), .pulse_in(pulse_comb),
    .direct(out_direct), .div_out(div_out)
  );

  AST_ARM_ONE_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !hold_req) |=> run_q);  // R5
  AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (rst)
    (hold_req && !run_q) |=> (!run_q && !pulse_comb));  // R4
  AST_TERM_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (run_q && term && !hold_req) |=> (first_val == $past(first_ld) && last_val == $past(last_ld)));  // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    !last_borrow);  // R6
endmodule

// File: tb/tb_pdiv_counter.sv
module tb_pdiv_counter;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 195000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  mode_sel = 3'b100;
  logic        out_direct = 1'b1;
  logic [3:0]  pre_first = '0;
  logic [11:0] pre_dec = '0;
  logic [2:0]  pre_last = '0;
  logic        div_out;

  int checks = 0;
  int errors = 0;

  pdiv_counter dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .out_direct(out_direct),
    .pre_first(pre_first), .pre_dec(pre_dec), .pre_last(pre_last), .div_out(div_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [2:0]  mode;
    logic        dsel;
    logic [3:0]  f;
    logic [3:0]  a, b, c;
    logic [2:0]  t;
    logic [31:0] n;
  } vec_t;

  // Expected N hand-computed from the ratio formula and saturation rules
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'b110, 1'b1, 4'd9,  4'd7,  4'd4,  4'd8,  3'd0, 32'd8479},   // R1 m=10
    '{3'b001, 1'b1, 4'd7,  4'd15, 4'd15, 4'd15, 3'd1, 32'd21327},  // R2 max /8
    '{3'b111, 1'b1, 4'd1,  4'd3,  4'd2,  4'd0,  3'd0, 32'd47},     // R1 m=2
    '{3'b011, 1'b1, 4'd3,  4'd15, 4'd0,  4'd0,  3'd0, 32'd63},     // R2 digit 15
    '{3'b101, 1'b1, 4'd2,  4'd0,  4'd1,  4'd0,  3'd1, 32'd5052},   // R1 m=5
    '{3'b010, 1'b1, 4'd5,  4'd2,  4'd0,  4'd0,  3'd0, 32'd25},     // R1 alt m=10
    '{3'b001, 1'b1, 4'd12, 4'd0,  4'd0,  4'd0,  3'd5, 32'd8007},   // R3 F,T clamp
    '{3'b000, 1'b1, 4'd3,  4'd1,  4'd0,  4'd0,  3'd0, 32'd13},     // R9 decimal direct
    '{3'b101, 1'b1, 4'd7,  4'd2,  4'd0,  4'd0,  3'd0, 32'd14},     // R3 F clamp m=5
    '{3'b011, 1'b0, 4'd0,  4'd1,  4'd0,  4'd0,  3'd0, 32'd4},      // R9 registered
    '{3'b111, 1'b1, 4'd0,  4'd1,  4'd0,  4'd0,  3'd0, 32'd2},      // R1 smallest
    '{3'b110, 1'b1, 4'd0,  4'd3,  4'd0,  4'd0,  3'd7, 32'd30},     // R3 T clamp m=10
    '{3'b111, 1'b0, 4'd1,  4'd0,  4'd0,  4'd0,  3'd1, 32'd2001}    // R1 top stage m=2
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_presets(input logic [3:0] f, input logic [3:0] a, input logic [3:0] b,
                             input logic [3:0] c, input logic [2:0] t);
    pre_first = f;
    pre_dec   = {c, b, a};
    pre_last  = t;
  endtask

  // Hold 3 clocks on the presets, then switch to the counting mode
  task automatic enter_mode(input logic [2:0] m, input logic d);
    mode_sel = 3'b100;
    repeat (3) @(negedge clk);
    mode_sel   = m;
    out_direct = d;
  endtask

  // Negedges until div_out is seen HIGH (cap returns cap+1)
  task automatic wait_pulse(input int start, input int cap, output int k);
    k = start;
    while (k <= cap) begin
      @(negedge clk);
      k++;
      if (div_out) return;
    end
  endtask

  initial begin
    int k;
    // R10 reset state
    repeat (3) begin
      @(negedge clk);
      check(div_out == 1'b0, "R10 reset output low", div_out, 0);
    end
    rst = 1'b0;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      set_presets(VECS[i].f, VECS[i].a, VECS[i].b, VECS[i].c, VECS[i].t);
      enter_mode(VECS[i].mode, VECS[i].dsel);
      wait_pulse(0, int'(VECS[i].n) + 5, k);
      check(k == int'(VECS[i].n) + (VECS[i].dsel ? 0 : 1),
            "R5 first pulse after arming edge", k, int'(VECS[i].n) + (VECS[i].dsel ? 0 : 1));
      @(negedge clk);
      check(div_out == 1'b0, "R9 pulse one clock wide", div_out, 0);
      wait_pulse(1, int'(VECS[i].n) + 5, k);
      check(k == int'(VECS[i].n), "R1 R6 steady period", k, int'(VECS[i].n));
    end

    // R8 fixed 10000 in registered decimal code; first cycle from presets (20)
    set_presets(4'd0, 4'd2, 4'd0, 4'd0, 3'd0);
    enter_mode(3'b000, 1'b0);
    wait_pulse(0, 40, k);
    check(k == 21, "R8 first cycle from presets", k, 21);
    set_presets(4'd5, 4'd9, 4'd1, 4'd0, 3'd1);
    wait_pulse(0, 10010, k);
    check(k == 10000, "R8 fixed ratio ignores presets", k, 10000);

    // R7 hold requested two clocks before a pulse
    set_presets(4'd5, 4'd2, 4'd0, 4'd0, 3'd0);
    enter_mode(3'b110, 1'b1);
    wait_pulse(0, 40, k);
    check(k == 25, "R5 first pulse N=25", k, 25);
    repeat (24) @(negedge clk);
    mode_sel = 3'b100;
    @(negedge clk);
    check(div_out == 1'b1, "R7 pulse kept on late hold", div_out, 1);
    begin
      int highs = 0;
      repeat (30) begin
        @(negedge clk);
        if (div_out) highs++;
      end
      check(highs == 0, "R4 hold keeps output low", highs, 0);
    end

    // R10 asynchronous reset during a pulse, then re-arm
    set_presets(4'd0, 4'd1, 4'd0, 4'd0, 3'd0);
    mode_sel = 3'b111;
    wait_pulse(0, 10, k);
    #1 rst = 1'b1;
    #1 check(div_out == 1'b0, "R10 async reset drops output", div_out, 0);
    @(negedge clk);
    rst = 1'b0;
    wait_pulse(0, 10, k);
    check(k == 2, "R10 re-arm after reset", k, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WD_CYCLES, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule